// File: doc/BRIEF.md
# Periodic Match Timer

A 16-bit up-counter with a selectable prescaler and a 16-bit compare register. It produces a periodic event with a fixed count interval. Software programs the block over a small byte-wide register bus. The count can be read or preset one byte at a time.

When the count reaches the compare value, the hardware can do three things. It can return the counter to zero, raise a compare flag, and pulse a converter-start strobe. Because no software reload sits in the loop, the period does not depend on interrupt latency. For example, a 1 ms period at a 5 MHz tick rate uses a compare value of 4999 with clear-on-match. The older method presets the counter to 0xEC78 on every overflow, and that still works.

The `tick_en` input qualifies every clock. An interrupt controller consumes the two flag outputs, and an external converter consumes the strobe.

Top module: `match_timer`

## Requirements
- R1: After reset, all registers read 0 and `irq_ovf`, `irq_cmp` and `conv_start` are low.
- R2: Address 0 is the low byte of the count and address 1 is the high byte. Addresses 2 and 3 hold the low and high bytes of the compare value. Each byte can be read and written on its own. A carry from the low byte increments the high byte.
- R3: Control register bits [2:1] (address 4) select the prescale ratio as 1, 2, 4 or 8 for codes 0, 1, 2 and 3. The counter advances once every that many enabled clocks.
- R4: A write to either count byte clears the prescaler's internal count. The next advance then comes a full prescale interval after the write.
- R5: The counter and prescaler hold their values while control bit 0 (run) is low or `tick_en` is low.
- R6: An advance from 0xFFFF sets the overflow flag. This flag is bit 0 of the flag register at address 5 and drives `irq_ovf`.
- R7: Control bits [4:3] select the compare mode. Code 0 ignores matches. Code 1 sets the compare flag only. Code 2 sets the flag and clears the counter. Code 3 does the same as code 2 and also strobes the converter. A match is an advance taken while the count equals the compare value. In modes 2 and 3 the match-to-match period is (compare+1) × ratio clocks.
- R8: `conv_start` is high for one clock per match, and only in mode 3.
- R9: The compare flag is bit 1 of address 5 and drives `irq_cmp`. Both flags stay set until software writes 1 to the flag's bit. If an event occurs in the same clock as the clear, the flag stays set.
- R10: If a count write falls in the same clock as a match, the written value is kept. That clock produces no match event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Clock qualifier for the prescaler |
| we | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq_ovf | output | 1 | Overflow flag |
| irq_cmp | output | 1 | Compare flag |
| conv_start | output | 1 | Converter-start strobe |

## Verification
The prescaler phase cannot be read at the ports. It shows up only as the clock on which the count next advances. So a prescaler that is not cleared on a count write is caught by reading the count on the exact clocks before and after a full interval. A wrong compare or clear decision shows in the spacing between strobes within one period. The spacing is measured twice per setting, so an off-by-one in the match point appears at once. A corrupted flag becomes visible on the next clock after the event or the clear write.

// File: rtl/match_timer.sv
module match_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       we,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_ovf,
  output logic       irq_cmp,
  output logic       conv_start
);
  localparam logic [2:0] A_CLO = 3'd0, A_CHI = 3'd1, A_MLO = 3'd2, A_MHI = 3'd3,
                         A_CTL = 3'd4, A_FLG = 3'd5;

  logic [15:0] cnt, cmp;
  logic        run;
  logic [1:0]  psel, mode;
  logic [2:0]  pcnt;
  logic [3:0]  div_m;
  logic        cnt_wr, active, step, hit, wrap, clr_ovf, clr_cmp;

  assign div_m   = (4'd1 << psel) - 4'd1;
  assign cnt_wr  = we && (addr == A_CLO || addr == A_CHI);
  assign active  = run && tick_en;
  assign step    = active && !cnt_wr && ((pcnt & div_m[2:0]) == div_m[2:0]);
  assign hit     = step && (mode != 2'd0) && (cnt == cmp);
  assign wrap    = step && (cnt == 16'hffff);
  assign clr_ovf = we && addr == A_FLG && wdata[0];
  assign clr_cmp = we && addr == A_FLG && wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; cmp <= '0; run <= 1'b0; psel <= '0; mode <= '0; pcnt <= '0;
      irq_ovf <= 1'b0; irq_cmp <= 1'b0; conv_start <= 1'b0;
    end else begin
      if (cnt_wr) pcnt <= '0;
      else if (active) pcnt <= step ? 3'd0 : pcnt + 3'd1;

      if (we && addr == A_CLO)      cnt[7:0]  <= wdata;
      else if (we && addr == A_CHI) cnt[15:8] <= wdata;
      else if (step)                cnt <= (hit && mode[1]) ? 16'd0 : cnt + 16'd1;

      if (we && addr == A_MLO) cmp[7:0]  <= wdata;
      if (we && addr == A_MHI) cmp[15:8] <= wdata;
      if (we && addr == A_CTL) begin
        run <= wdata[0]; psel <= wdata[2:1]; mode <= wdata[4:3];
      end

      irq_ovf    <= wrap | (irq_ovf & ~clr_ovf);
      irq_cmp    <= hit  | (irq_cmp & ~clr_cmp);
      conv_start <= hit && (mode == 2'd3);
    end
  end

  always_comb begin
    case (addr)
      A_CLO:   rdata = cnt[7:0];
      A_CHI:   rdata = cnt[15:8];
      A_MLO:   rdata = cmp[7:0];
      A_MHI:   rdata = cmp[15:8];
      A_CTL:   rdata = {3'b000, mode, psel, run};
      A_FLG:   rdata = {6'b0, irq_cmp, irq_ovf};
      default: rdata = 8'h00;
    endcase
  end

  a_r8_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> cnt == 16'd0);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && cmp != 16'd0 && !we) |=> !conv_start);
  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !we) |=> $stable(cnt));
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cmp && !clr_cmp) |=> irq_cmp);
  a_r6_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 16'hffff && !we) ##1 (cnt == 16'h0000) |-> irq_ovf);
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_CLO) |=> cnt[7:0] == $past(wdata));
endmodule

// File: tb/match_timer_tb.sv
module match_timer_tb;
  localparam int PERIOD = 10;
  localparam int NV = 6;
  localparam int VCMP [NV] = '{4, 4, 9, 2, 0, 4999};
  localparam int VPS  [NV] = '{0, 1, 2, 3, 0, 0};
  localparam int VPER [NV] = '{5, 10, 40, 24, 1, 5000};

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b1, we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic irq_ovf, irq_cmp, conv_start;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  match_timer u_dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp), .conv_start(conv_start));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a; #1; v = rdata;
  endtask

  task automatic rd16(output int v);
    int lo, hi;
    rd(3'd0, lo); rd(3'd1, hi); v = hi * 256 + lo;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input int cv, input int cmpv, input logic [7:0] ctl);
    wr(3'd4, 8'h00);
    wr(3'd2, cmpv[7:0]); wr(3'd3, cmpv[15:8]);
    wr(3'd1, cv[15:8]);  wr(3'd0, cv[7:0]);
    wr(3'd5, 8'h03);
    wr(3'd4, ctl);
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!conv_start && n < 50000);
  endtask

  initial begin
    #(PERIOD * 180000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v, g;
    idle(2); rst_n = 1'b1; @(negedge clk);
    for (int a = 0; a < 6; a++) begin rd(a[2:0], v); chk("R1 reg after reset", v, 0); end
    chk("R1 outputs after reset", {irq_ovf, irq_cmp, conv_start}, 0);

    for (int i = 0; i < NV; i++) begin
      setup(0, VCMP[i], {3'b0, 2'd3, VPS[i][1:0], 1'b1});
      gap(g);
      gap(g); chk("R7 R3 period", g, VPER[i]);
      gap(g); chk("R8 R7 period repeat", g, VPER[i]);
    end

    setup(16'hEC78, 0, 8'h01); idle(10); rd16(v);
    chk("R2 preset readback and count", v, 16'hEC82);
    setup(16'h00FF, 0, 8'h01); idle(1); rd16(v);
    chk("R2 carry into high byte", v, 16'h0100);

    setup(16'hFFFE, 0, 8'h01); idle(1);
    chk("R6 no flag before wrap", irq_ovf, 0);
    idle(1); rd16(v);
    chk("R6 wrapped count", v, 0);
    chk("R6 overflow flag", irq_ovf, 1);
    wr(3'd5, 8'h01);
    chk("R9 overflow W1C", irq_ovf, 0);

    setup(0, 0, {3'b0, 2'd2, 2'd0, 1'b1}); idle(2);
    wr(3'd5, 8'h02);
    chk("R9 set wins over clear", irq_cmp, 1);

    setup(0, 3, {3'b0, 2'd1, 2'd0, 1'b1}); idle(10); rd16(v);
    chk("R7 mode1 no clear", v, 10);
    chk("R7 mode1 flag", irq_cmp, 1);
    setup(0, 3, {3'b0, 2'd0, 2'd0, 1'b1}); idle(10); rd16(v);
    chk("R7 mode0 count", v, 10);
    chk("R7 mode0 no flag", irq_cmp, 0);

    setup(0, 3, {3'b0, 2'd2, 2'd0, 1'b1});
    g = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (conv_start) g++; end
    chk("R8 no strobe in mode2", g, 0);
    chk("R7 mode2 flag", irq_cmp, 1);

    setup(0, 0, {3'b0, 2'd0, 2'd3, 1'b1}); idle(3);
    wr(3'd0, 8'h10); idle(7); rd16(v);
    chk("R4 prescaler cleared, no advance yet", v, 16'h10);
    idle(1); rd16(v);
    chk("R4 R3 advance after 8", v, 16'h11);

    setup(16'h40, 0, 8'h01); tick_en = 1'b0; idle(5); rd16(v);
    chk("R5 tick_en low holds", v, 16'h40);
    tick_en = 1'b1;
    wr(3'd4, 8'h00); idle(5); rd16(v);
    chk("R5 run low holds", v, 16'h41);

    wr(3'd4, 8'h00); wr(3'd2, 8'd5); wr(3'd3, 8'd0);
    wr(3'd1, 8'd0); wr(3'd0, 8'd4); wr(3'd5, 8'h03);
    wr(3'd4, {3'b0, 2'd3, 2'd0, 1'b1}); idle(1);
    wr(3'd0, 8'h20); rd16(v);
    chk("R10 write wins over match", v, 16'h20);
    chk("R10 no match flag", irq_cmp, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule